// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `OP_W` bits (4 by default) and returns a product twice as wide. It does this over several clock cycles. A start pulse latches both operands into shift registers that are zero-extended to the product width. The same pulse clears the accumulator.

On every step after that, three things happen:
- the multiplicand register moves one place toward the MSB;
- the multiplier register moves one place toward the LSB;
- the accumulator takes the sum of itself and the multiplicand, through a ripple-carry adder, only when the multiplier LSB is 1.

Zero detectors watch both operand registers. The run stops as soon as either register is empty, so small multipliers finish early. The result is then held with `done` high until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `product` = 0 and `done` = 0.
- R2: For every pair of unsigned operands, the final `product` equals `mcand_in * mplier_in`. The adder never produces a carry out of the product width.
- R3: Once `done` is high, `done` and `product` stay unchanged at every edge where `start` is low.
- R4: A `start` sampled during a run is ignored. The run completes with the operands captured at its own start, and its latency is unchanged.
- R5: If either operand is 0, `done` goes high at the first edge after the load edge, and `product` is 0.
- R6: If both operands are nonzero, `done` goes high at edge L+1 after the load edge. L is the bit position of the highest 1 in `mplier_in`, plus one.
- R7: A `start` sampled while idle or done counts as the load edge. After that edge, `done` is 0 and `product` is 0.
- R8: On each step, the multiplicand register shifts left by one bit and the multiplier register shifts right by one bit, with zero fill. The accumulator adds only when the multiplier LSB is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication; honoured only when not running |
| mcand_in | input | OP_W | Multiplicand, unsigned |
| mplier_in | input | OP_W | Multiplier, unsigned |
| product | output | 2*OP_W | Accumulated product |
| done | output | 1 | High while a finished result is held |

## Verification
The hardest case to reach from the ports is a second `start` arriving while a run is still in progress. It only matters if it lands inside the short window before the zero detector ends the run.

The bench covers this with a second sweep over all operand pairs. In that sweep it raises `start` with different operands on the edge right after the load. It skips pairs that finish in a single step, because for those the window does not exist. The bench then requires both the product and the latency to match the original operands.

// File: rtl/mul_pkg.sv
// Package: shared controller state encoding for the shift-and-add multiplier.
// Assumes: only the three states below are ever used.
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_ripple_adder.sv
// Ripple-carry adder: W full-adder cells chained LSB to MSB.
// Assumes: combinational use only; carry-in and carry-out exposed as single bits.
module mul_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = ci;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    assign co = c[W];
endmodule

// File: rtl/mul_shift_reg.sv
// Bidirectional shift register with parallel load.
// Load places the narrow input in the low bits and zeroes the rest.
// Shift moves one place per clock when enabled; dir=1 is toward the MSB,
// dir=0 is toward the LSB, and the vacated end fills with 0.
// Priority: reset, then load, then shift.
// Assumes: IN_W <= W.
module mul_shift_reg #(
    parameter int IN_W = 4,
    parameter int W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic            sh,
    input  logic            dir,
    input  logic [IN_W-1:0] d,
    output logic [W-1:0]    q
);
    localparam int PAD_W = W - IN_W;

    logic [W-1:0] d_ext;
    logic [W-1:0] nxt;

    // Zero-extend the load value to full width.
    if (PAD_W > 0) begin : g_pad
        assign d_ext = {{PAD_W{1'b0}}, d};
    end else begin : g_nopad
        assign d_ext = d;
    end

    // Select the next register value by priority.
    always_comb begin
        if (ld) begin
            nxt = d_ext;
        end else if (sh) begin
            nxt = dir ? {q[W-2:0], 1'b0} : {1'b0, q[W-1:1]};
        end else begin
            nxt = q;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/mul_zero_det.sv
// Zero detector: output is 1 only when every bit of the input bus is 0.
// Assumes: any width W >= 1.
module mul_zero_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    output logic         z
);
    // Reduce the bus with a NOR.
    assign z = ~|x;
endmodule

// File: rtl/mul_acc.sv
// Accumulator: a W-bit register fed by W two-input selectors with one shared
// select. sel=1 loads the sum; sel=0 recirculates the held value.
// clr zeroes the register synchronously and outranks sel.
// Assumes: clr and sel come from the same clock domain.
module mul_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sel,
    input  logic [W-1:0] sum,
    output logic [W-1:0] q
);
    logic [W-1:0] mux_y;

    // Per-bit 2:1 selector sharing one select line.
    for (genvar i = 0; i < W; i++) begin : g_sel
        assign mux_y[i] = sel ? sum[i] : q[i];
    end

    // Accumulator register with reset and start clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else begin
            q <= mux_y;
        end
    end
endmodule

// File: rtl/shift_add_mul.sv
// Sequential shift-and-add unsigned multiplier.
// A start pulse, taken when idle or done, loads the operands zero-extended
// into two shift registers and clears the accumulator. Each RUN step adds the
// multiplicand when the multiplier LSB is 1, then shifts the multiplicand left
// and the multiplier right. The run ends when either register is all zero.
// done holds the result until the next accepted start.
// Assumes: a synchronous reset; start is ignored while running.
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic [2*OP_W-1:0] product,
    output logic              done
);
    localparam int P_W = 2 * OP_W;

    mul_state_e     state;
    mul_state_e     state_nxt;
    logic           running;
    logic           load;
    logic           step;
    logic           finish;
    logic           mp_zero;
    logic           mc_zero;
    logic           add_en;
    logic           add_co;
    logic [P_W-1:0] q_mc;
    logic [P_W-1:0] q_mp;
    logic [P_W-1:0] add_s;

    assign running = (state == ST_RUN);
    assign load    = start && !running;
    assign finish  = mp_zero || mc_zero;
    assign step    = running && !finish;
    assign add_en  = step && q_mp[0];

    // Multiplicand register: shifts toward the MSB on each step.
    mul_shift_reg #(.IN_W(OP_W), .W(P_W)) u_mc (
        .clk(clk), .rst_n(rst_n), .ld(load), .sh(step), .dir(1'b1),
        .d(mcand_in), .q(q_mc)
    );

    // Multiplier register: shifts toward the LSB on each step.
    mul_shift_reg #(.IN_W(OP_W), .W(P_W)) u_mp (
        .clk(clk), .rst_n(rst_n), .ld(load), .sh(step), .dir(1'b0),
        .d(mplier_in), .q(q_mp)
    );

    mul_zero_det #(.W(P_W)) u_zmp (.x(q_mp), .z(mp_zero));
    mul_zero_det #(.W(P_W)) u_zmc (.x(q_mc), .z(mc_zero));

    mul_ripple_adder #(.W(P_W)) u_add (
        .a(product), .b(q_mc), .ci(1'b0), .s(add_s), .co(add_co)
    );

    mul_acc #(.W(P_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(load), .sel(add_en),
        .sum(add_s), .q(product)
    );

    // Next-state logic for the controller.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) state_nxt = ST_RUN;
            ST_RUN:           if (finish) state_nxt = ST_DONE;
            default:          state_nxt = ST_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/shift_add_mul_chk.sv
// Checker for shift_add_mul: temporal properties over ports and datapath
// registers. Attached by bind below.
module shift_add_mul_chk #(
    parameter int OP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [2*OP_W-1:0] product,
    input logic              running,
    input logic              finish,
    input logic              add_co,
    input logic [2*OP_W-1:0] q_mc,
    input logic [2*OP_W-1:0] q_mp
);
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q_mp == '0 || q_mc == '0)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product))); // R3
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !finish && start) |=> (q_mp == ($past(q_mp) >> 1))); // R4
    AST_MCAND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !finish) |=> (q_mc == ($past(q_mc) << 1))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !finish) |-> !add_co); // R2
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running) |=> (product == '0 && !done)); // R7
endmodule

bind shift_add_mul shift_add_mul_chk #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .product(product),
    .running(running), .finish(finish), .add_co(add_co),
    .q_mc(q_mc), .q_mp(q_mp)
);

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
    localparam int OP_W = 4;
    localparam int P_W  = 2 * OP_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [OP_W-1:0] mcand_in = '0;
    logic [OP_W-1:0] mplier_in = '0;
    logic [P_W-1:0] product;
    logic           done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    shift_add_mul #(.OP_W(OP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand_in(mcand_in),
        .mplier_in(mplier_in), .product(product), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bitlen(input int v);
        int r = 0;
        for (int i = 0; i < OP_W; i++) if (v[i]) r = i + 1;
        return r;
    endfunction

    // One multiplication; disturb=1 raises start with other operands mid-run.
    task automatic run_pair(input int a, input int b, input bit disturb);
        int exp_lat;
        int lat;
        int exp_p;
        bit zero_op;
        exp_p   = a * b;
        zero_op = (a == 0) || (b == 0);
        exp_lat = zero_op ? 1 : bitlen(b) + 1;
        @(negedge clk);
        mcand_in  = a[OP_W-1:0];
        mplier_in = b[OP_W-1:0];
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(!done && product == 0, "R7", {23'd0, done, product}, 0);
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            if (disturb && k == 1) begin
                mcand_in  = ~a[OP_W-1:0];
                mplier_in = ~b[OP_W-1:0];
                start     = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
        if (zero_op) check(lat == 1 && product == 0, "R5", lat * 1000 + product, 1000);
        else check(lat == exp_lat, disturb ? "R4" : "R6", lat, exp_lat);
        check(product == exp_p, disturb ? "R4" : "R2 R8", product, exp_p);
    endtask

    initial begin
        wait (cyc > 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(product == 0 && !done, "R1", {23'd0, done, product}, 0);
        rst_n = 1'b1;

        for (int a = 0; a < (1 << OP_W); a++)
            for (int b = 0; b < (1 << OP_W); b++)
                run_pair(a, b, 1'b0);

        // Hold check: result stays put with no start.
        run_pair(13, 11, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done && product == 143, "R3", {23'd0, done, product}, 256 + 143);
        end

        // Start during a run, only where the run spans more than one step.
        for (int a = 1; a < (1 << OP_W); a++)
            for (int b = 2; b < (1 << OP_W); b++)
                run_pair(a, b, 1'b1);

        // Reset after a finished result.
        run_pair(15, 15, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(product == 0 && !done, "R1", {23'd0, done, product}, 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule